// File: doc/BRIEF.md
# Address Region Protection Checker

This block decides, for each memory access, whether the access is allowed, and returns the 8-bit memory attribute that applies to it. Software programs up to sixteen address regions. Each region is bounded by a 32-byte-aligned lower bound and an inclusive upper bound, so a region spans from its lower bound through its upper bound plus 31. Each region carries the following fields:

- an access-permission pair;
- an execute-never bit;
- a shareability field;
- a 3-bit pointer into eight byte-wide attribute slots, which are held in two 32-bit attribute words.

Regions are reached indirectly. A selector register names one region, and the bound registers then read and write that region.

An access is presented for one cycle with `acc_valid`. Because the byte offset inside a 32-byte granule never changes the outcome, the access carries only its granule address. The access also carries write, privilege, instruction-fetch and handler-mode flags. One cycle later the block shows the verdict on `rsp_fault` and the attribute on `rsp_attr`, qualified by `rsp_valid`.

A small response machine has two states:

- ST_IDLE: no result is shown.
- ST_RESP: a result is shown.

The machine has four transitions:

- IDLE_TO_RESP is taken when `acc_valid` is high.
- RESP_TO_RESP is taken when accesses arrive back to back.
- RESP_TO_IDLE is taken when no access follows.
- IDLE_HOLD keeps the machine in ST_IDLE when there is no access.

Register offsets on `reg_addr`:

| Offset | Register | Layout |
|---|---|---|
| 0 | control | bit0 global enable, bit1 keep regions active in handler mode, bit2 default map for privileged accesses |
| 1 | selector | bits 3:0 select the region |
| 2 | lower bound | bits 31:5 lower bound, bits 4:3 shareability, bits 2:1 permission, bit0 execute-never |
| 3 | upper bound | bits 31:5 upper bound, bit4 reads zero, bits 3:1 attribute pointer, bit0 region enable |
| 4 | attribute word 0 | slots 0 to 3 |
| 5 | attribute word 1 | slots 4 to 7 |

Within an attribute word, slot k sits in byte lane k mod 4. The permission field is decoded as follows:

- Bit 2 set means the region is read-only.
- Bit 1 set means unprivileged accesses are allowed.

Top module: `region_guard`

## Requirements
- R1: After reset the control register, the selector and every region read back as zero. `rsp_valid`, `rsp_fault` and `rsp_attr` are all 0.
- R2: Writes to offsets 2 and 3 update only the region named by the selector, and reads of those offsets return that region's fields in the layout given above. A write to offset 2 leaves the region enable bit unchanged.
- R3: An enabled region matches an address A exactly when lower bound ≤ A ≤ upper bound + 31.
- R4: A single matching region whose attribute pointer is 0 to 3 yields byte lane p of attribute word 0. A pointer of 4 to 7 yields byte lane p−4 of attribute word 1.
- R5: With the global enable (control bit0) clear, every access passes and the attribute is 0.
- R6: An instruction fetch that hits an execute-never region faults.
- R7: A write that hits a region whose permission bit 2 is set faults. A read of that region passes.
- R8: An unprivileged access to a region whose permission bit 1 is clear faults. A privileged access to it passes.
- R9: When two or more enabled regions match, the access faults and the attribute is 0.
- R10: When no enabled region matches, a privileged access passes only if control bit2 is set, and any other access faults. The attribute is 0 in both cases.
- R11: An access with `acc_handler` high is checked against the regions only when control bit1 is set. Otherwise it passes with attribute 0.
- R12: `rsp_valid` is high in the cycle after each cycle in which `acc_valid` is high, and low otherwise. While `rsp_valid` is low, `rsp_fault` and `rsp_attr` are 0.
- R13: A region whose enable bit is clear never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| acc_valid | input | 1 | Access present this cycle |
| acc_gaddr | input | 27 | Access address bits 31:5 (granule address) |
| acc_write | input | 1 | Access is a write |
| acc_priv | input | 1 | Access is privileged |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_handler | input | 1 | Access is made during fault or NMI handling |
| rsp_valid | output | 1 | Result of the previous cycle's access is shown |
| rsp_fault | output | 1 | Access is refused |
| rsp_attr | output | 8 | Memory attribute of the matching region |

## Verification
The assertions check the following on every cycle:

- the one-cycle response timing and the zeroed outputs between responses;
- the pass-through with global enable clear and in handler mode without the keep bit;
- the fault with zero attribute on overlapping matches;
- the fault on unprivileged accesses that match no region.

Only the bench's scenarios can show which region an address falls in, the inclusive upper edge and the selection of attribute byte lanes. The same holds for the per-region permission and execute-never decisions and the indirect register programming with read-back, because these depend on the values programmed into the regions.

// File: rtl/rg_pkg.sv
package rg_pkg;
    localparam int ADDR_W   = 32;
    localparam int GRAN_W   = 5;
    localparam int GADDR_W  = ADDR_W - GRAN_W;
    localparam int DATA_W   = 32;
    localparam int IDX_W    = 3;
    localparam int SLOT_W   = 8;
    localparam int LANES    = DATA_W / SLOT_W;
    localparam int LANE_W   = $clog2(LANES);
    localparam int REG_AW   = 3;

    localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] RA_RSEL  = 3'd1;
    localparam logic [REG_AW-1:0] RA_BASE  = 3'd2;
    localparam logic [REG_AW-1:0] RA_LIMIT = 3'd3;
    localparam logic [REG_AW-1:0] RA_ATTR0 = 3'd4;
    localparam logic [REG_AW-1:0] RA_ATTR1 = 3'd5;

    typedef enum logic {ST_IDLE, ST_RESP} rg_state_e;

    typedef struct packed {
        logic pdef;
        logic keep;
        logic en;
    } rg_ctrl_t;
endpackage

// File: rtl/rg_regfile.sv
module rg_regfile
    import rg_pkg::*;
#(
    parameter int N_REGIONS = 16,
    localparam int RSEL_W = $clog2(N_REGIONS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                reg_we,
    input  logic [REG_AW-1:0]                   reg_addr,
    input  logic [DATA_W-1:0]                   reg_wdata,
    output logic [DATA_W-1:0]                   reg_rdata,
    output rg_ctrl_t                            ctrl_o,
    output logic [DATA_W-1:0]                   attr_lo_o,
    output logic [DATA_W-1:0]                   attr_hi_o,
    output logic [N_REGIONS-1:0][GADDR_W-1:0]   base_o,
    output logic [N_REGIONS-1:0][GADDR_W-1:0]   limit_o,
    output logic [N_REGIONS-1:0][1:0]           ap_o,
    output logic [N_REGIONS-1:0]                xn_o,
    output logic [N_REGIONS-1:0][IDX_W-1:0]     idx_o,
    output logic [N_REGIONS-1:0]                en_o
);
    logic [RSEL_W-1:0]              rsel_q;
    logic [N_REGIONS-1:0][1:0]      share_q;

    // global registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_o    <= '0;
            rsel_q    <= '0;
            attr_lo_o <= '0;
            attr_hi_o <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                RA_CTRL:  ctrl_o    <= rg_ctrl_t'(reg_wdata[2:0]);
                RA_RSEL:  rsel_q    <= reg_wdata[RSEL_W-1:0];
                RA_ATTR0: attr_lo_o <= reg_wdata;
                RA_ATTR1: attr_hi_o <= reg_wdata;
                default: ;
            endcase
        end
    end

    // per-region registers, reached through the selector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_o  <= '0;
            limit_o <= '0;
            share_q <= '0;
            ap_o    <= '0;
            xn_o    <= '0;
            idx_o   <= '0;
            en_o    <= '0;
        end else if (reg_we) begin
            for (int i = 0; i < N_REGIONS; i++) begin
                if (rsel_q == RSEL_W'(i)) begin
                    if (reg_addr == RA_BASE) begin
                        base_o[i]  <= reg_wdata[DATA_W-1:GRAN_W];
                        share_q[i] <= reg_wdata[4:3];
                        ap_o[i]    <= reg_wdata[2:1];
                        xn_o[i]    <= reg_wdata[0];
                    end else if (reg_addr == RA_LIMIT) begin
                        limit_o[i] <= reg_wdata[DATA_W-1:GRAN_W];
                        idx_o[i]   <= reg_wdata[3:1];
                        en_o[i]    <= reg_wdata[0];
                    end
                end
            end
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL:  reg_rdata = DATA_W'(ctrl_o);
            RA_RSEL:  reg_rdata = DATA_W'(rsel_q);
            RA_BASE:  reg_rdata = {base_o[rsel_q], share_q[rsel_q], ap_o[rsel_q], xn_o[rsel_q]};
            RA_LIMIT: reg_rdata = {limit_o[rsel_q], 1'b0, idx_o[rsel_q], en_o[rsel_q]};
            RA_ATTR0: reg_rdata = attr_lo_o;
            RA_ATTR1: reg_rdata = attr_hi_o;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rg_match.sv
module rg_match
    import rg_pkg::*;
#(
    parameter int N_REGIONS = 16
) (
    input  logic [GADDR_W-1:0]                  gaddr,
    input  logic [N_REGIONS-1:0][GADDR_W-1:0]   base_i,
    input  logic [N_REGIONS-1:0][GADDR_W-1:0]   limit_i,
    input  logic [N_REGIONS-1:0]                en_i,
    output logic [N_REGIONS-1:0]                hit_o
);
    // one parallel comparator pair per region
    for (genvar g = 0; g < N_REGIONS; g++) begin : g_cmp
        assign hit_o[g] = en_i[g] && (gaddr >= base_i[g]) && (gaddr <= limit_i[g]);
    end
endmodule

// File: rtl/rg_decide.sv
module rg_decide
    import rg_pkg::*;
#(
    parameter int N_REGIONS = 16,
    localparam int RSEL_W = $clog2(N_REGIONS)
) (
    input  rg_ctrl_t                            ctrl_i,
    input  logic [DATA_W-1:0]                   attr_lo_i,
    input  logic [DATA_W-1:0]                   attr_hi_i,
    input  logic [N_REGIONS-1:0]                hit_i,
    input  logic [N_REGIONS-1:0][1:0]           ap_i,
    input  logic [N_REGIONS-1:0]                xn_i,
    input  logic [N_REGIONS-1:0][IDX_W-1:0]     idx_i,
    input  logic                                acc_write,
    input  logic                                acc_priv,
    input  logic                                acc_fetch,
    input  logic                                acc_handler,
    output logic                                fault_o,
    output logic [SLOT_W-1:0]                   attr_o
);
    logic [RSEL_W-1:0]  sel;
    logic               multi;
    logic               bypass;
    logic [IDX_W-1:0]   pidx;
    logic [DATA_W-1:0]  word;
    logic [SLOT_W-1:0]  slot;

    always_comb begin
        sel = '0;
        for (int i = 0; i < N_REGIONS; i++) begin
            if (hit_i[i]) sel = RSEL_W'(i);
        end
        multi  = |(hit_i & (hit_i - 1'b1));
        bypass = !ctrl_i.en || (acc_handler && !ctrl_i.keep);
        pidx   = idx_i[sel];
        word   = pidx[IDX_W-1] ? attr_hi_i : attr_lo_i;
        slot   = word[{pidx[LANE_W-1:0], 3'b000} +: SLOT_W];

        fault_o = 1'b0;
        attr_o  = '0;
        if (bypass) begin
            fault_o = 1'b0;
        end else if (multi) begin
            fault_o = 1'b1;
        end else if (hit_i == '0) begin
            fault_o = !(acc_priv && ctrl_i.pdef);
        end else begin
            fault_o = (acc_fetch && xn_i[sel])
                   || (acc_write && ap_i[sel][1])
                   || (!acc_priv && !ap_i[sel][0]);
            attr_o  = slot;
        end
    end
endmodule

// File: rtl/region_guard.sv
module region_guard
    import rg_pkg::*;
#(
    parameter int N_REGIONS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [2:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                acc_valid,
    input  logic [26:0]         acc_gaddr,
    input  logic                acc_write,
    input  logic                acc_priv,
    input  logic                acc_fetch,
    input  logic                acc_handler,
    output logic                rsp_valid,
    output logic                rsp_fault,
    output logic [7:0]          rsp_attr
);
    rg_ctrl_t                           ctrl;
    logic [DATA_W-1:0]                  attr_lo, attr_hi;
    logic [N_REGIONS-1:0][GADDR_W-1:0]  base_v, limit_v;
    logic [N_REGIONS-1:0][1:0]          ap_v;
    logic [N_REGIONS-1:0]               xn_v, en_v;
    logic [N_REGIONS-1:0][IDX_W-1:0]    idx_v;
    logic [N_REGIONS-1:0]               hit_vec;
    logic                               fault_d;
    logic [SLOT_W-1:0]                  attr_d;
    logic                               ctrl_en, ctrl_keep;
    rg_state_e                          state_q, state_d;

    assign ctrl_en   = ctrl.en;
    assign ctrl_keep = ctrl.keep;

    rg_regfile #(.N_REGIONS(N_REGIONS)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl_o(ctrl),
        .attr_lo_o(attr_lo), .attr_hi_o(attr_hi), .base_o(base_v),
        .limit_o(limit_v), .ap_o(ap_v), .xn_o(xn_v), .idx_o(idx_v), .en_o(en_v)
    );

    rg_match #(.N_REGIONS(N_REGIONS)) u_match (
        .gaddr(acc_gaddr), .base_i(base_v), .limit_i(limit_v),
        .en_i(en_v), .hit_o(hit_vec)
    );

    rg_decide #(.N_REGIONS(N_REGIONS)) u_decide (
        .ctrl_i(ctrl), .attr_lo_i(attr_lo), .attr_hi_i(attr_hi), .hit_i(hit_vec),
        .ap_i(ap_v), .xn_i(xn_v), .idx_i(idx_v), .acc_write(acc_write),
        .acc_priv(acc_priv), .acc_fetch(acc_fetch), .acc_handler(acc_handler),
        .fault_o(fault_d), .attr_o(attr_d)
    );

    // response state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = acc_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = acc_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    // response outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_fault <= 1'b0;
            rsp_attr  <= '0;
        end else if (acc_valid) begin
            rsp_fault <= fault_d;
            rsp_attr  <= attr_d;
        end else begin
            rsp_fault <= 1'b0;
            rsp_attr  <= '0;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);
endmodule

// File: rtl/rg_guard_sva.sv
module rg_guard_sva #(
    parameter int N_REGIONS = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 acc_valid,
    input logic                 acc_priv,
    input logic                 acc_handler,
    input logic                 ctrl_en,
    input logic                 ctrl_keep,
    input logic [N_REGIONS-1:0] hit_vec,
    input logic                 rsp_valid,
    input logic                 rsp_fault,
    input logic [7:0]           rsp_attr
);
    logic checked;
    assign checked = ctrl_en && !(acc_handler && !ctrl_keep);

    // R12
    resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);
    // R12
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);
    // R12
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_fault && rsp_attr == 8'h00));
    // R5
    off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !ctrl_en) |=> (!rsp_fault && rsp_attr == 8'h00));
    // R11
    handler_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && ctrl_en && acc_handler && !ctrl_keep) |=> (!rsp_fault && rsp_attr == 8'h00));
    // R9
    overlap_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && checked && $countones(hit_vec) > 1) |=> (rsp_fault && rsp_attr == 8'h00));
    // R10
    unpriv_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && checked && hit_vec == '0 && !acc_priv) |=> (rsp_fault && rsp_attr == 8'h00));
endmodule

bind region_guard rg_guard_sva #(.N_REGIONS(N_REGIONS)) u_sva (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_priv(acc_priv),
    .acc_handler(acc_handler), .ctrl_en(ctrl_en), .ctrl_keep(ctrl_keep),
    .hit_vec(hit_vec), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_attr(rsp_attr)
);

// File: tb/region_guard_bench.sv
`timescale 1ns/1ps
module region_guard_bench;
    import rg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [26:0] acc_gaddr = '0;
    logic        acc_write = 1'b0, acc_priv = 1'b0, acc_fetch = 1'b0, acc_handler = 1'b0;
    logic        rsp_valid, rsp_fault;
    logic [7:0]  rsp_attr;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    region_guard u_region_guard (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_gaddr(acc_gaddr), .acc_write(acc_write), .acc_priv(acc_priv),
        .acc_fetch(acc_fetch), .acc_handler(acc_handler), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_attr(rsp_attr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic prog(input int i, input logic [31:0] lo, input logic [31:0] hi,
                        input logic [1:0] sh, input logic [1:0] ap, input logic xn,
                        input logic [2:0] pidx, input logic en);
        wr(RA_RSEL, 32'(i));
        wr(RA_LIMIT, 32'h0);
        wr(RA_BASE, {lo[31:5], sh, ap, xn});
        wr(RA_LIMIT, {hi[31:5], 1'b0, pidx, en});
    endtask

    // result packed as {valid, fault, attr}
    task automatic expect_acc(input string req, input logic [31:0] addr,
                              input logic w, input logic p, input logic f, input logic h,
                              input logic ef, input logic [7:0] ea);
        @(negedge clk);
        acc_valid = 1'b1; acc_gaddr = addr[31:5];
        acc_write = w; acc_priv = p; acc_fetch = f; acc_handler = h;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_priv = 1'b0; acc_fetch = 1'b0; acc_handler = 1'b0;
        check(req, {22'h0, rsp_valid, rsp_fault, rsp_attr}, {22'h0, 1'b1, ef, ea});
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 outputs", {29'h0, rsp_valid, rsp_fault, |rsp_attr}, 32'h0);
        rd(RA_CTRL, d);  check("R1 ctrl", d, 32'h0);
        rd(RA_RSEL, d);  check("R1 rsel", d, 32'h0);
        rd(RA_LIMIT, d); check("R1 limit", d, 32'h0);
        rd(RA_BASE, d);  check("R1 base", d, 32'h0);
    endtask

    task automatic t_setup;
        wr(RA_ATTR0, 32'h44332211);
        wr(RA_ATTR1, 32'h88776655);
        prog(0, 32'h1000, 32'h1FE0, 2'b00, 2'b01, 1'b0, 3'd2, 1'b1);
        prog(1, 32'h2000, 32'h2000, 2'b10, 2'b11, 1'b1, 3'd5, 1'b1);
        prog(2, 32'h3000, 32'h30E0, 2'b00, 2'b00, 1'b0, 3'd7, 1'b1);
        wr(RA_CTRL, 32'h1);
    endtask

    task automatic t_readback;
        logic [31:0] d;
        wr(RA_RSEL, 32'd1);
        rd(RA_RSEL, d);  check("R2 rsel", d, 32'h1);
        rd(RA_BASE, d);  check("R2 base", d, 32'h2017);
        rd(RA_LIMIT, d); check("R2 limit", d, 32'h200B);
        wr(RA_BASE, 32'h2017);
        rd(RA_LIMIT, d); check("R2 base write keeps enable", d, 32'h200B);
        wr(RA_RSEL, 32'd0);
        rd(RA_LIMIT, d); check("R2 other region", d, 32'h1FE5);
    endtask

    task automatic t_coverage;
        expect_acc("R3 low edge",  32'h1000, 0, 0, 0, 0, 1'b0, 8'h33);
        expect_acc("R3 high edge", 32'h1FFF, 0, 0, 0, 0, 1'b0, 8'h33);
        expect_acc("R3 above",     32'h2020, 0, 0, 0, 0, 1'b1, 8'h00);
        expect_acc("R3 below",     32'h0FFF, 0, 0, 0, 0, 1'b1, 8'h00);
    endtask

    task automatic t_attr;
        expect_acc("R4 slot 2", 32'h1400, 0, 1, 0, 0, 1'b0, 8'h33);
        expect_acc("R4 slot 5", 32'h2010, 0, 0, 0, 0, 1'b0, 8'h66);
        expect_acc("R4 slot 7", 32'h3050, 0, 1, 0, 0, 1'b0, 8'h88);
    endtask

    task automatic t_perm;
        expect_acc("R6 xn fetch",       32'h2004, 0, 1, 1, 0, 1'b1, 8'h66);
        expect_acc("R6 exec ok",        32'h1100, 0, 0, 1, 0, 1'b0, 8'h33);
        expect_acc("R7 ro write",       32'h2010, 1, 1, 0, 0, 1'b1, 8'h66);
        expect_acc("R7 rw write",       32'h1100, 1, 0, 0, 0, 1'b0, 8'h33);
        expect_acc("R8 unpriv blocked", 32'h3000, 0, 0, 0, 0, 1'b1, 8'h88);
        expect_acc("R8 priv write",     32'h30FF, 1, 1, 0, 0, 1'b0, 8'h88);
    endtask

    task automatic t_overlap;
        prog(3, 32'h1800, 32'h1800, 2'b00, 2'b01, 1'b0, 3'd0, 1'b1);
        expect_acc("R9 overlap",     32'h1810, 0, 1, 0, 0, 1'b1, 8'h00);
        expect_acc("R9 outside",     32'h1000, 0, 1, 0, 0, 1'b0, 8'h33);
        wr(RA_RSEL, 32'd3);
        wr(RA_LIMIT, {27'h1800 >> 5, 1'b0, 3'd0, 1'b0});
        expect_acc("R13 disabled region", 32'h1810, 0, 1, 0, 0, 1'b0, 8'h33);
    endtask

    task automatic t_nomatch;
        expect_acc("R10 priv no default",  32'h9000, 0, 1, 0, 0, 1'b1, 8'h00);
        wr(RA_CTRL, 32'h5);
        expect_acc("R10 priv default map", 32'h9000, 0, 1, 0, 0, 1'b0, 8'h00);
        expect_acc("R10 unpriv",           32'h9000, 0, 0, 0, 0, 1'b1, 8'h00);
        wr(RA_CTRL, 32'h1);
    endtask

    task automatic t_handler;
        expect_acc("R11 bypass",  32'h2010, 1, 0, 0, 1, 1'b0, 8'h00);
        wr(RA_CTRL, 32'h3);
        expect_acc("R11 kept",    32'h2010, 1, 0, 0, 1, 1'b1, 8'h66);
        wr(RA_CTRL, 32'h1);
    endtask

    task automatic t_disabled;
        wr(RA_CTRL, 32'h0);
        expect_acc("R5 ro write",  32'h2010, 1, 0, 0, 0, 1'b0, 8'h00);
        expect_acc("R5 unmatched", 32'h9000, 0, 0, 1, 0, 1'b0, 8'h00);
        wr(RA_CTRL, 32'h1);
    endtask

    task automatic t_timing;
        expect_acc("R12 response", 32'h1000, 0, 0, 0, 0, 1'b0, 8'h33);
        @(negedge clk);
        check("R12 single cycle", {29'h0, rsp_valid, rsp_fault, |rsp_attr}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_setup;
        t_readback;
        t_coverage;
        t_attr;
        t_perm;
        t_overlap;
        t_nomatch;
        t_handler;
        t_disabled;
        t_timing;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule